// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 32 level-sensitive interrupt lines and sends each enabled line to one of two processor outputs: a normal request (`irq_o`) or a fast request (`fiq_o`). A per-line select bit makes the choice. Enable bits are changed through a set register and a clear register, so software never needs a read-modify-write sequence.

Sixteen vector slots turn a pending normal request into a handler address. Each slot has a 32-bit handler address and a control word. The control word names a source line and has an enable bit. A read of the vector register returns the handler of the winning slot. If no enabled slot matches a pending normal request, the read returns a default handler address instead. A small two-state machine tracks the interrupt in service:

- `ST_IDLE`: nothing is in service. A vector read that finds a matching slot takes the **claim** transition to `ST_SERVICE` and latches that slot.
- `ST_SERVICE`: a vector read that finds a slot of strictly higher priority (lower number) takes the **preempt** transition. It stays in `ST_SERVICE` and latches the new slot. Any write to the vector register takes the **acknowledge** transition back to `ST_IDLE`.

The register bus uses word addresses, which are the byte offset divided by four. The map is:

| Word address | Register | Access |
|---|---|---|
| 0x00 | normal request status | read only |
| 0x01 | fast request status | read only |
| 0x02 | raw lines | read only |
| 0x03 | select | read/write |
| 0x04 | enable | write sets, read returns the enables |
| 0x05 | enable clear | write only |
| 0x0C | vector | read presents, write acknowledges |
| 0x0D | default vector | read/write |
| 0x40+n | slot n handler address | read/write |
| 0x80+n | slot n control | read/write |

Reads are combinational in the same cycle as `bus_sel`. Writes and read side effects take effect at the clock edge.

Top module: `vic_ctrl`

## Requirements
- R1: After reset, the following are all zero: enables, selects, every slot register and the default vector. Both outputs are low, and a vector read returns 0.
- R2: Writing word 0x04 sets every enable bit that is 1 in the data. Writing word 0x05 clears every enable bit that is 1 in the data. A read of word 0x04 returns the enables.
- R3: `irq_o` is the OR of lines & enable & ~select. `fiq_o` is the OR of lines & enable & select. A select bit of 1 means the fast output.
- R4: Word 0x00 reads lines & enable & ~select. Word 0x01 reads lines & enable & select. Word 0x02 reads the raw lines. Word 0x03 reads the select register back.
- R5: The slot n handler lives at word 0x40+n and the slot n control at word 0x80+n. In the control word, bits [4:0] are the source number and bit 5 is the slot enable. A read returns those 6 bits, with the upper bits zero.
- R6: In `ST_IDLE`, a vector read returns the handler of the lowest-numbered enabled slot whose source is pending in the normal request status (word 0x00). Lines routed to the fast output never match.
- R7: When no enabled slot matches, a vector read returns the default vector at word 0x0D.
- R8: A vector read in `ST_IDLE` with a match latches that slot as in service. Until acknowledge, later reads return that slot's handler, even after its line drops or only lower-priority slots match.
- R9: In `ST_SERVICE`, a vector read that finds a matching slot numbered strictly lower than the one in service presents that slot's handler and latches it as in service.
- R10: Any write to the vector register (word 0x0C) returns the controller to `ST_IDLE`, whatever the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| bus_sel | input | 1 | bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 10 | word address (byte offset / 4) |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, combinational |
| irq_lines | input | 32 | raw level interrupt lines |
| irq_o | output | 1 | normal interrupt request |
| fiq_o | output | 1 | fast interrupt request |

## Verification
The bench goes after priority among several matching slots. A design that scanned from the top slot down, or let a disabled slot match, would return the wrong handler. It also tests lines routed to the fast output: a design that matched them against slots would present a vector where the default is due. The in-service rules get their own tests: a controller that re-arbitrated on every read would drop the in-service handler once its line fell, and one that ignored preemption would keep a lower-priority handler in front of a newly pending higher-priority one. Random line patterns over random slot programming, each followed or not by an acknowledge, cover combinations of these cases.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int LINES     = 32;
    localparam int SLOTS     = 16;
    localparam int DATA_W    = 32;
    localparam int WADDR_W   = 10;

    localparam logic [WADDR_W-1:0] W_IRQ_STAT = 10'h000;
    localparam logic [WADDR_W-1:0] W_FIQ_STAT = 10'h001;
    localparam logic [WADDR_W-1:0] W_RAW      = 10'h002;
    localparam logic [WADDR_W-1:0] W_SELECT   = 10'h003;
    localparam logic [WADDR_W-1:0] W_EN_SET   = 10'h004;
    localparam logic [WADDR_W-1:0] W_EN_CLR   = 10'h005;
    localparam logic [WADDR_W-1:0] W_VECTOR   = 10'h00C;
    localparam logic [WADDR_W-1:0] W_DEFAULT  = 10'h00D;
    localparam logic [3:0]         PG_HANDLER = 4'h1;
    localparam logic [3:0]         PG_CTRL    = 4'h2;

    typedef enum logic {
        ST_IDLE,
        ST_SERVICE
    } vec_state_e;
endpackage

// File: rtl/vic_line_mask.sv
module vic_line_mask #(
    parameter int NL = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_we,
    input  logic          clr_we,
    input  logic          sel_we,
    input  logic [NL-1:0] wdata,
    input  logic [NL-1:0] lines,
    output logic [NL-1:0] en_q,
    output logic [NL-1:0] sel_q,
    output logic [NL-1:0] irq_pend,
    output logic [NL-1:0] fiq_pend,
    output logic          irq_o,
    output logic          fiq_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            sel_q <= '0;
        end else begin
            if (set_we) en_q <= en_q | wdata;
            else if (clr_we) en_q <= en_q & ~wdata;
            if (sel_we) sel_q <= wdata;
        end
    end

    always_comb begin
        irq_pend = lines & en_q & ~sel_q;
        fiq_pend = lines & en_q & sel_q;
        irq_o    = |irq_pend;
        fiq_o    = |fiq_pend;
    end

    a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((en_q & $past(wdata)) == $past(wdata)));
    a_r2_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((en_q & $past(wdata)) == '0));
    a_r3_one_route: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(lines & en_q) |-> !(irq_o && fiq_o));
endmodule

// File: rtl/vic_slot_bank.sv
module vic_slot_bank #(
    parameter int NS = 16,
    parameter int NL = 32,
    parameter int DW = 32,
    localparam int SW = $clog2(NS),
    localparam int LW = $clog2(NL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hnd_we,
    input  logic          ctl_we,
    input  logic [SW-1:0] wr_idx,
    input  logic [DW-1:0] wdata,
    input  logic [SW-1:0] rd_idx,
    output logic [DW-1:0] rd_handler,
    output logic [DW-1:0] rd_ctrl,
    input  logic [NL-1:0] pend,
    output logic          hit,
    output logic [SW-1:0] hit_idx,
    input  logic [SW-1:0] pres_idx,
    output logic [DW-1:0] pres_handler
);
    logic [DW-1:0] handler_q [NS];
    logic [LW-1:0] src_q     [NS];
    logic [NS-1:0] slot_en_q;

    for (genvar g = 0; g < NS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                handler_q[g]    <= '0;
                src_q[g]        <= '0;
                slot_en_q[g]    <= 1'b0;
            end else begin
                if (hnd_we && wr_idx == SW'(g)) handler_q[g] <= wdata;
                if (ctl_we && wr_idx == SW'(g)) begin
                    src_q[g]     <= wdata[LW-1:0];
                    slot_en_q[g] <= wdata[LW];
                end
            end
        end
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NS - 1; i >= 0; i--) begin
            if (slot_en_q[i] && pend[src_q[i]]) begin
                hit     = 1'b1;
                hit_idx = i[SW-1:0];
            end
        end
    end

    always_comb begin
        rd_handler   = handler_q[rd_idx];
        rd_ctrl      = '0;
        rd_ctrl[LW:0] = {slot_en_q[rd_idx], src_q[rd_idx]};
        pres_handler = handler_q[pres_idx];
    end

    a_r6_hit_is_live: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (slot_en_q[hit_idx] && pend[src_q[hit_idx]]));
endmodule

// File: rtl/vic_vector_fsm.sv
module vic_vector_fsm
    import vic_pkg::*;
#(
    parameter int NS = 16,
    localparam int SW = $clog2(NS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vec_rd,
    input  logic          vec_ack,
    input  logic          hit,
    input  logic [SW-1:0] hit_idx,
    output logic          pres_valid,
    output logic [SW-1:0] pres_idx
);
    vec_state_e    state_q, state_d;
    logic [SW-1:0] cur_q, cur_d;
    logic          preempt;

    assign preempt = hit && (hit_idx < cur_q);

    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        unique case (state_q)
            ST_IDLE: begin
                if (vec_rd && hit) begin
                    state_d = ST_SERVICE;
                    cur_d   = hit_idx;
                end
            end
            ST_SERVICE: begin
                if (vec_ack) state_d = ST_IDLE;
                else if (vec_rd && preempt) cur_d = hit_idx;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
        end
    end

    always_comb begin
        pres_valid = 1'b0;
        pres_idx   = '0;
        unique case (state_q)
            ST_IDLE: begin
                pres_valid = hit;
                pres_idx   = hit_idx;
            end
            ST_SERVICE: begin
                pres_valid = 1'b1;
                pres_idx   = preempt ? hit_idx : cur_q;
            end
        endcase
    end

    a_r10_ack_idles: assert property (@(posedge clk) disable iff (!rst_n)
        vec_ack |=> (state_q == ST_IDLE));
    a_r8_hold_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SERVICE && !vec_ack && !(vec_rd && preempt)) |=>
        (state_q == ST_SERVICE && $stable(cur_q)));
    a_r9_preempt_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SERVICE && vec_rd && preempt) |=> (cur_q == $past(hit_idx)));
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
    import vic_pkg::*;
#(
    parameter int NUM_LINES = LINES,
    parameter int NUM_SLOTS = SLOTS,
    localparam int SW = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [WADDR_W-1:0]   bus_waddr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_LINES-1:0] irq_lines,
    output logic                 irq_o,
    output logic                 fiq_o
);
    logic wr, rd;
    logic slot_ok, is_hnd, is_ctl;
    logic [NUM_LINES-1:0] en_q, sel_q, irq_pend, fiq_pend;
    logic [DATA_W-1:0] default_q, rd_handler, rd_ctrl, pres_handler;
    logic hit, pres_valid;
    logic [SW-1:0] hit_idx, pres_idx, slot_idx;

    assign wr       = bus_sel && bus_wr;
    assign rd       = bus_sel && !bus_wr;
    assign slot_ok  = bus_waddr[5:0] < 6'(NUM_SLOTS);
    assign is_hnd   = (bus_waddr[9:6] == PG_HANDLER) && slot_ok;
    assign is_ctl   = (bus_waddr[9:6] == PG_CTRL) && slot_ok;
    assign slot_idx = bus_waddr[SW-1:0];

    vic_line_mask #(.NL(NUM_LINES)) u_mask (
        .clk(clk), .rst_n(rst_n),
        .set_we(wr && bus_waddr == W_EN_SET),
        .clr_we(wr && bus_waddr == W_EN_CLR),
        .sel_we(wr && bus_waddr == W_SELECT),
        .wdata(bus_wdata[NUM_LINES-1:0]), .lines(irq_lines),
        .en_q(en_q), .sel_q(sel_q), .irq_pend(irq_pend), .fiq_pend(fiq_pend),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    vic_slot_bank #(.NS(NUM_SLOTS), .NL(NUM_LINES), .DW(DATA_W)) u_slots (
        .clk(clk), .rst_n(rst_n),
        .hnd_we(wr && is_hnd), .ctl_we(wr && is_ctl),
        .wr_idx(slot_idx), .wdata(bus_wdata),
        .rd_idx(slot_idx), .rd_handler(rd_handler), .rd_ctrl(rd_ctrl),
        .pend(irq_pend), .hit(hit), .hit_idx(hit_idx),
        .pres_idx(pres_idx), .pres_handler(pres_handler)
    );

    vic_vector_fsm #(.NS(NUM_SLOTS)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .vec_rd(rd && bus_waddr == W_VECTOR),
        .vec_ack(wr && bus_waddr == W_VECTOR),
        .hit(hit), .hit_idx(hit_idx),
        .pres_valid(pres_valid), .pres_idx(pres_idx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) default_q <= '0;
        else if (wr && bus_waddr == W_DEFAULT) default_q <= bus_wdata;
    end

    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            if (is_hnd) bus_rdata = rd_handler;
            else if (is_ctl) bus_rdata = rd_ctrl;
            else begin
                unique case (bus_waddr)
                    W_IRQ_STAT: bus_rdata = DATA_W'(irq_pend);
                    W_FIQ_STAT: bus_rdata = DATA_W'(fiq_pend);
                    W_RAW:      bus_rdata = DATA_W'(irq_lines);
                    W_SELECT:   bus_rdata = DATA_W'(sel_q);
                    W_EN_SET:   bus_rdata = DATA_W'(en_q);
                    W_VECTOR:   bus_rdata = pres_valid ? pres_handler : default_q;
                    W_DEFAULT:  bus_rdata = default_q;
                    default:    bus_rdata = '0;
                endcase
            end
        end
    end

    a_r7_default_when_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_waddr == W_VECTOR && !pres_valid) |-> (bus_rdata == default_q));
endmodule

// File: tb/vic_ctrl_tb.sv
module vic_ctrl_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_sel = 0, bus_wr = 0;
    logic [9:0]  bus_waddr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [31:0] irq_lines = '0;
    logic        irq_o, fiq_o;

    int checks = 0, fails = 0, cycles = 0;
    bit done = 0;

    logic [31:0] m_en, m_sel, m_def;
    logic [31:0] m_hnd [16];
    logic [4:0]  m_src [16];
    logic        m_sen [16];
    bit          m_busy;
    int          m_cur;

    vic_ctrl u_dut (.*);

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            fails++; checks++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            report();
        end
    end

    task automatic report();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [9:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_waddr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_waddr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 0;
    endtask

    function automatic int best_slot();
        logic [31:0] p = irq_lines & m_en & ~m_sel;
        for (int i = 0; i < 16; i++)
            if (m_sen[i] && p[m_src[i]]) return i;
        return -1;
    endfunction

    function automatic logic [31:0] exp_vec();
        int b = best_slot();
        if (!m_busy) return (b >= 0) ? m_hnd[b] : m_def;
        if (b >= 0 && b < m_cur) return m_hnd[b];
        return m_hnd[m_cur];
    endfunction

    task automatic vec_read(string tag);
        logic [31:0] d, e;
        int b;
        e = exp_vec();
        b = best_slot();
        rd(10'h00C, d);
        chk(tag, d, e);
        if (!m_busy && b >= 0) begin m_busy = 1; m_cur = b; end
        else if (m_busy && b >= 0 && b < m_cur) m_cur = b;
    endtask

    task automatic ack();
        wr(10'h00C, $urandom);
        m_busy = 0;
    endtask

    task automatic set_slot(int n, logic [31:0] h, logic [4:0] s, logic e);
        wr(10'h040 + 10'(n), h);
        wr(10'h080 + 10'(n), {26'h3FFFFFF, e, s});
        m_hnd[n] = h; m_src[n] = s; m_sen[n] = e;
    endtask

    task automatic drive_lines(logic [31:0] v);
        logic [31:0] d;
        @(negedge clk);
        irq_lines = v;
        #1;
        chk("R3 irq_o", 32'(irq_o), 32'(|(v & m_en & ~m_sel)));
        chk("R3 fiq_o", 32'(fiq_o), 32'(|(v & m_en & m_sel)));
    endtask

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20417));
        m_en = 0; m_sel = 0; m_def = 0; m_busy = 0; m_cur = 0;
        for (int i = 0; i < 16; i++) begin m_hnd[i] = 0; m_src[i] = 0; m_sen[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        irq_lines = 32'hFFFF_FFFF;
        #1;
        chk("R1 irq_o", 32'(irq_o), 0);
        chk("R1 fiq_o", 32'(fiq_o), 0);
        rd(10'h004, d); chk("R1 enable", d, 0);
        rd(10'h003, d); chk("R1 select", d, 0);
        rd(10'h040, d); chk("R1 slot0 handler", d, 0);
        rd(10'h08F, d); chk("R1 slot15 ctrl", d, 0);
        rd(10'h00D, d); chk("R1 default", d, 0);
        rd(10'h00C, d); chk("R1 vector", d, 0);

        // R2 enable set/clear
        wr(10'h004, 32'h0000_F0F0); rd(10'h004, d); chk("R2 set", d, 32'h0000_F0F0);
        wr(10'h004, 32'h0F00_0000); rd(10'h004, d); chk("R2 set or", d, 32'h0F00_F0F0);
        wr(10'h005, 32'h0100_00F0); rd(10'h004, d); chk("R2 clear", d, 32'h0E00_F000);
        wr(10'h005, 32'hFFFF_FFFF); rd(10'h004, d); chk("R2 clear all", d, 0);

        // R4 status views
        wr(10'h004, 32'hFFFF_FFFF); m_en = 32'hFFFF_FFFF;
        wr(10'h003, 32'h0000_00FF); m_sel = 32'h0000_00FF;
        drive_lines(32'h0000_0181);
        rd(10'h000, d); chk("R4 irq status", d, 32'h0000_0100);
        rd(10'h001, d); chk("R4 fiq status", d, 32'h0000_0081);
        rd(10'h002, d); chk("R4 raw", d, 32'h0000_0181);
        rd(10'h003, d); chk("R4 select", d, 32'h0000_00FF);

        // R5 slot readback, upper control bits dropped
        set_slot(3, 32'hCAFE_0003, 5'd17, 1);
        rd(10'h043, d); chk("R5 handler", d, 32'hCAFE_0003);
        rd(10'h083, d); chk("R5 ctrl", d, 32'h0000_0031);

        // R7 default with no match, R6 fast-routed line does not match
        wr(10'h00D, 32'hDEF0_0000); m_def = 32'hDEF0_0000;
        set_slot(0, 32'hA000_0000, 5'd2, 1);
        drive_lines(32'h0000_0004);
        vec_read("R6 fiq line ignored -> R7 default");
        drive_lines(32'h0000_0200);
        vec_read("R7 default unmatched");
        wr(10'h003, 0); m_sel = 0;

        // R6 priority, R8 hold, R9 preempt, R10 ack
        set_slot(5, 32'hA000_0005, 5'd9, 1);
        set_slot(2, 32'hA000_0002, 5'd9, 0);
        drive_lines(32'h0002_0200);
        vec_read("R6 lowest slot wins");
        drive_lines(0);
        vec_read("R8 hold after line drop");
        drive_lines(32'h0000_0200);
        vec_read("R8 lower slot cannot replace");
        drive_lines(32'h0000_0004);
        vec_read("R9 higher slot preempts");
        ack();
        drive_lines(32'h0000_0200);
        vec_read("R10 after ack re-arbitrates");
        ack();

        // random phase
        for (int it = 0; it < 40; it++) begin
            for (int n = 0; n < 16; n++)
                set_slot(n, $urandom, 5'($urandom), ($urandom % 4) != 0);
            wr(10'h004, 32'hFFFF_FFFF);
            d = $urandom & $urandom;
            wr(10'h005, d); m_en = ~d;
            d = $urandom & $urandom & $urandom;
            wr(10'h003, d); m_sel = d;
            for (int k = 0; k < 12; k++) begin
                drive_lines($urandom & $urandom & $urandom);
                rd(10'h000, d); chk("R4 random irq status", d, irq_lines & m_en & ~m_sel);
                vec_read("R6/R8/R9 random vector");
                if ($urandom % 3 == 0) ack();
            end
            ack();
        end
        report();
    end
endmodule